// File: doc/BRIEF.md
# Digit-Serial GHASH Accumulator

This unit produces the GHASH authentication value used by Galois/Counter Mode. A 128-bit hash subkey is presented on `h_key`, a `start` pulse opens a new message, and the caller then streams 128-bit blocks through a valid/ready handshake. Each block is tagged as associated data or ciphertext, carries a byte-count code and may be marked as the final one. Each accepted block is masked to its valid bytes and XORed into a running accumulator. The sum is then multiplied by the subkey in GF(2^128).

The multiplier is digit-serial. It takes 16 multiplicand bits per clock, most significant first, so one multiplication costs eight clocks. After the final block the unit builds the length block by itself. The upper 64 bits hold the associated-data bit count and the lower 64 bits hold the ciphertext bit count. It hashes that block and reports the result with a one-cycle `done` pulse. It then waits idle for the next `start`.

Top module: `ghash_mac`

## Requirements
- R1: After reset, `ready` and `done` are 0 and `hash` is all zeros.
- R2: A `start` pulse clears the accumulator and both byte counters, aborts any operation in progress, and makes `ready` high in the cycle after the pulse.
- R3: A block is taken only on a clock edge where `ready` and `blk_valid` are both high. `ready` is low for exactly 8 cycles after that edge and high again in the 9th.
- R4: Each accepted block X updates the accumulator Y to (Y xor X)·H in GF(2^128). The product uses the GCM bit order: the most significant bit of the vector is the coefficient of x^0. The reduction constant is 0xE1 followed by 120 zero bits.
- R5: Size code n (0..14) keeps the n+1 most significant bytes of `blk_data` and zeroes the rest before hashing. Code 15 keeps all 16 bytes.
- R6: Associated-data blocks (`blk_kind`=1) and ciphertext blocks (`blk_kind`=0) are counted in separate 64-bit byte counters. Each accepted block adds its size code plus one to the counter of its kind. Empty associated data or empty ciphertext gives a zero count.
- R7: After the block flagged `blk_last`, the unit hashes the length block {associated bytes·8, ciphertext bytes·8} without any input. Blocks offered during that time are ignored.
- R8: `done` is high for exactly one cycle, 17 cycles after the edge that accepts the final block. `hash` then holds the GHASH result until the next completion.
- R9: While idle, `ready` stays low and `blk_valid` has no effect: `done` stays low and `hash` keeps its value.
- R10: A `start` issued while a multiplication is running gives the same final hash as a start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_key | input | 128 | Hash subkey H, held stable during a message |
| start | input | 1 | Opens a new message, clearing accumulator and counters |
| blk_valid | input | 1 | Block offered |
| blk_kind | input | 1 | 1 = associated data, 0 = ciphertext |
| blk_last | input | 1 | Offered block is the final one of the message |
| blk_size | input | 4 | Valid byte count minus one (15 = full block) |
| blk_data | input | 128 | Block contents, left-aligned |
| ready | output | 1 | Unit can take a block this cycle |
| done | output | 1 | One-cycle pulse: `hash` carries a new result |
| hash | output | 128 | Final GHASH value |

## Verification
All results are compared against a bit-serial GF(2^128) reference in the bench. Several subkeys are used, and each separates a different fault. A random H exercises the full reduction path. An all-ones H shifts out a one at every step. The multiplicative identity (top bit only) makes the hash the plain XOR of the masked blocks, which isolates masking and length-block faults from multiplier faults. The zero subkey must give zero. Messages with no associated data, with no ciphertext, and with every size code 0..15 on a single block check the masking and the split byte counts. Directed runs check ready timing, done latency and pulse width, that idle and length-phase offers are ignored, and a restart in the middle of a multiplication.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int GH_BLK_W   = 128;
  localparam int GH_DIGIT_W = 16;
  localparam int GH_CNT_W   = 64;

  typedef enum logic [2:0] {
    GH_IDLE,
    GH_TAKE,
    GH_MUL,
    GH_LEN,
    GH_LENMUL
  } gh_state_e;
endpackage

// File: rtl/ghash_digit_step.sv
module ghash_digit_step #(
  parameter int W = 128,
  parameter int D = 16
) (
  input  logic [W-1:0] v_in,
  input  logic [W-1:0] z_in,
  input  logic [D-1:0] bits,
  output logic [W-1:0] v_out,
  output logic [W-1:0] z_out
);
  localparam logic [W-1:0] RED = {8'hE1, {(W-8){1'b0}}};

  logic [W-1:0] vch [D+1];
  logic [W-1:0] zch [D+1];

  assign vch[0] = v_in;
  assign zch[0] = z_in;

  for (genvar g = 0; g < D; g++) begin : g_bit
    assign zch[g+1] = bits[D-1-g] ? (zch[g] ^ vch[g]) : zch[g];
    assign vch[g+1] = vch[g][0] ? ((vch[g] >> 1) ^ RED) : (vch[g] >> 1);
  end

  assign v_out = vch[D];
  assign z_out = zch[D];
endmodule

// File: rtl/ghash_digit_mul.sv
module ghash_digit_mul #(
  parameter int W = 128,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] v_init,
  input  logic [W-1:0] b_init,
  output logic         run,
  output logic         fin,
  output logic [W-1:0] prod
);
  localparam int STEPS = W / D;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [W-1:0]  v_q, z_q, b_q;
  logic [W-1:0]  v_nx, z_nx;
  logic [CW-1:0] cnt;

  ghash_digit_step #(.W(W), .D(D)) u_step (
    .v_in  (v_q),
    .z_in  (z_q),
    .bits  (b_q[W-1 -: D]),
    .v_out (v_nx),
    .z_out (z_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      z_q <= '0;
      b_q <= '0;
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      v_q <= v_init;
      z_q <= '0;
      b_q <= b_init;
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      v_q <= v_nx;
      z_q <= z_nx;
      b_q <= b_q << D;
      if (cnt == LAST) run <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign fin  = run && (cnt == LAST);
  assign prod = z_nx;

  // R4: the final digit follows a running digit with the previous count
  assert_fin_prev_R4: assert property (@(posedge clk) disable iff (rst)
    fin |-> ($past(run) && ($past(cnt) == CW'(STEPS - 2))));

  // R4: a load always begins a fresh count at zero
  assert_load_restart_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (run && cnt == '0 && !fin));
endmodule

// File: rtl/ghash_block_mask.sv
module ghash_block_mask #(
  parameter int W    = 128,
  parameter int SZ_W = 4
) (
  input  logic [W-1:0]    data,
  input  logic [SZ_W-1:0] size,
  output logic [W-1:0]    masked
);
  localparam int NB = W / 8;

  for (genvar gb = 0; gb < NB; gb++) begin : g_byte
    localparam logic [SZ_W-1:0] IDX = SZ_W'(gb);
    assign masked[W-1-8*gb -: 8] = (IDX <= size) ? data[W-1-8*gb -: 8] : 8'h00;
  end
endmodule

// File: rtl/ghash_mac.sv
module ghash_mac
  import ghash_pkg::*;
#(
  parameter int BLK_W   = GH_BLK_W,
  parameter int DIGIT_W = GH_DIGIT_W,
  parameter int CNT_W   = GH_CNT_W,
  localparam int SZ_W   = $clog2(BLK_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  h_key,
  input  logic              start,
  input  logic              blk_valid,
  input  logic              blk_kind,
  input  logic              blk_last,
  input  logic [SZ_W-1:0]   blk_size,
  input  logic [BLK_W-1:0]  blk_data,
  output logic              ready,
  output logic              done,
  output logic [BLK_W-1:0]  hash
);
  gh_state_e        state;
  logic [BLK_W-1:0] acc;
  logic [CNT_W-1:0] aad_cnt, ct_cnt;
  logic             last_q;

  logic [BLK_W-1:0] masked, len_blk, mul_in, prod;
  logic             accept, mul_load, mul_run, mul_fin;

  ghash_block_mask #(.W(BLK_W), .SZ_W(SZ_W)) u_mask (
    .data   (blk_data),
    .size   (blk_size),
    .masked (masked)
  );

  assign len_blk  = {aad_cnt[CNT_W-4:0], 3'b000, ct_cnt[CNT_W-4:0], 3'b000};
  assign accept   = (state == GH_TAKE) && blk_valid && !start;
  assign mul_load = accept || ((state == GH_LEN) && !start);
  assign mul_in   = ((state == GH_LEN) ? len_blk : masked) ^ acc;

  ghash_digit_mul #(.W(BLK_W), .D(DIGIT_W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .load   (mul_load),
    .v_init (h_key),
    .b_init (mul_in),
    .run    (mul_run),
    .fin    (mul_fin),
    .prod   (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= GH_IDLE;
      acc     <= '0;
      aad_cnt <= '0;
      ct_cnt  <= '0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      hash    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state   <= GH_TAKE;
        acc     <= '0;
        aad_cnt <= '0;
        ct_cnt  <= '0;
        last_q  <= 1'b0;
      end else begin
        case (state)
          GH_TAKE: if (blk_valid) begin
            state  <= GH_MUL;
            last_q <= blk_last;
            if (blk_kind) aad_cnt <= aad_cnt + CNT_W'(blk_size) + 1'b1;
            else          ct_cnt  <= ct_cnt  + CNT_W'(blk_size) + 1'b1;
          end
          GH_MUL: if (mul_fin) begin
            acc   <= prod;
            state <= last_q ? GH_LEN : GH_TAKE;
          end
          GH_LEN: state <= GH_LENMUL;
          GH_LENMUL: if (mul_fin) begin
            acc   <= prod;
            hash  <= prod;
            done  <= 1'b1;
            state <= GH_IDLE;
          end
          default: state <= GH_IDLE;
        endcase
      end
    end
  end

  assign ready = (state == GH_TAKE);

  // R2: start leaves a cleared accumulator and counters with ready raised
  assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (ready && acc == '0 && aad_cnt == '0 && ct_cnt == '0));

  // R3: a taken block drops ready on the next cycle
  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready);

  // R4: while waiting on a product, the multiplier is running
  assert_mul_active_R4: assert property (@(posedge clk) disable iff (rst)
    (state == GH_MUL || state == GH_LENMUL) |-> mul_run);

  // R6: an associated-data block grows only its own counter
  assert_aad_count_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && blk_kind) |=>
      (aad_cnt == $past(aad_cnt) + CNT_W'($past(blk_size)) + 1'b1) && $stable(ct_cnt));

  // R8: done never lasts two cycles
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: after completion the unit sits idle with ready low
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(start)) |-> (!ready && state == GH_IDLE));
endmodule

// File: tb/tb_ghash_mac.sv
`timescale 1ns/1ps
module tb_ghash_mac;
  localparam int W = 128;

  typedef struct packed {
    logic [127:0] h;
    logic [3:0]   n_aad;
    logic [3:0]   n_ct;
    logic [3:0]   sz_aad;
    logic [3:0]   sz_ct;
    logic [31:0]  seed;
  } case_t;

  localparam case_t CASES [6] = '{
    '{h: 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, n_aad: 4'd2, n_ct: 4'd3, sz_aad: 4'd15, sz_ct: 4'd15, seed: 32'h1234abcd},
    '{h: 128'hb83b533708bf535d0aa6e52980d53b78, n_aad: 4'd0, n_ct: 4'd2, sz_aad: 4'd15, sz_ct: 4'd6,  seed: 32'h0badf00d},
    '{h: {128{1'b1}},                           n_aad: 4'd1, n_ct: 4'd2, sz_aad: 4'd3,  sz_ct: 4'd0,  seed: 32'h5eed0003},
    '{h: 128'h0,                                n_aad: 4'd1, n_ct: 4'd1, sz_aad: 4'd15, sz_ct: 4'd9,  seed: 32'h77777777},
    '{h: {1'b1, 127'h0},                        n_aad: 4'd3, n_ct: 4'd0, sz_aad: 4'd10, sz_ct: 4'd15, seed: 32'hc0ffee11},
    '{h: 128'hacbef20579b4b8ebce889bac8732dad7, n_aad: 4'd1, n_ct: 4'd1, sz_aad: 4'd14, sz_ct: 4'd15, seed: 32'h31415926}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] h_key;
  logic         start, blk_valid, blk_kind, blk_last;
  logic [3:0]   blk_size;
  logic [127:0] blk_data;
  logic         ready, done;
  logic [127:0] hash;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ghash_mac dut (
    .clk(clk), .rst(rst), .h_key(h_key), .start(start),
    .blk_valid(blk_valid), .blk_kind(blk_kind), .blk_last(blk_last),
    .blk_size(blk_size), .blk_data(blk_data),
    .ready(ready), .done(done), .hash(hash)
  );

  function automatic logic [127:0] gmul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0;
    logic [127:0] v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z = z ^ v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'h0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] keep(input logic [127:0] d, input int sz);
    logic [127:0] m = ~({128{1'b1}} >> (8 * (sz + 1)));
    if (sz >= 15) m = {128{1'b1}};
    return d & m;
  endfunction

  function automatic logic [127:0] gen(input logic [31:0] s, input int i);
    logic [127:0] r;
    logic [31:0]  x = s ^ (32'(i) * 32'h9E3779B9) ^ 32'h2545F491;
    for (int k = 0; k < 4; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      r[32*k +: 32] = x;
    end
    return r;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start();
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic send(input logic [127:0] d, input logic kind, input int sz, input logic last);
    int guard = 0;
    while (!ready && guard < 100) begin tick(); guard++; end
    blk_valid = 1'b1; blk_data = d; blk_kind = kind; blk_size = 4'(sz); blk_last = last;
    tick();
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin tick(); n++; end
  endtask

  task automatic run_case(input case_t c, input string req, input logic hold);
    logic [127:0] y = '0;
    logic [63:0]  ab = 0, cb = 0;
    int n;
    h_key = c.h;
    do_start();
    for (int i = 0; i < c.n_aad; i++) begin
      int sz = (i == c.n_aad - 1) ? int'(c.sz_aad) : 15;
      logic [127:0] d = gen(c.seed, i);
      y = gmul(y ^ keep(d, sz), c.h);
      ab += 64'(sz + 1);
      send(d, 1'b1, sz, (c.n_ct == 0) && (i == c.n_aad - 1));
    end
    for (int i = 0; i < c.n_ct; i++) begin
      int sz = (i == c.n_ct - 1) ? int'(c.sz_ct) : 15;
      logic [127:0] d = gen(c.seed, 100 + i);
      y = gmul(y ^ keep(d, sz), c.h);
      cb += 64'(sz + 1);
      send(d, 1'b0, sz, i == c.n_ct - 1);
    end
    if (hold) begin
      blk_valid = 1'b1; blk_kind = 1'b1; blk_size = 4'd15; blk_data = {4{32'hdeadbeef}};
    end
    y = gmul(y ^ {ab << 3, cb << 3}, c.h);
    wait_done(n);
    blk_valid = 1'b0;
    check(done && hash == y, req, hash, y);
    check(n == 17, "R8 latency", 128'(n), 128'd17);
    tick();
    check(!done, "R8 pulse", 128'(done), 128'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        report();
      end
    end
  end

  initial begin
    logic [127:0] held;
    case_t c;
    rst = 1'b1; start = 1'b0; blk_valid = 1'b0; blk_kind = 1'b0; blk_last = 1'b0;
    blk_size = 4'd0; blk_data = '0; h_key = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check(!ready && !done && hash == '0, "R1 reset", {ready, done, hash[125:0]}, '0);

    // R4 R5 R6: table of messages walked by one loop
    for (int k = 0; k < 6; k++) run_case(CASES[k], $sformatf("R4 R6 table case %0d", k), 1'b0);

    // R5: every size code on a single ciphertext block
    for (int s = 0; s < 16; s++) begin
      c = CASES[0]; c.n_aad = 0; c.n_ct = 1; c.sz_ct = 4'(s); c.seed = 32'(s) * 32'h1111;
      run_case(c, $sformatf("R5 size code %0d", s), 1'b0);
    end

    // R9: offers while idle change nothing
    held = hash;
    blk_valid = 1'b1; blk_data = '1; blk_kind = 1'b1; blk_last = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(!ready && !done && hash == held, "R9 idle ignore", hash, held);
    end
    blk_valid = 1'b0; blk_last = 1'b0;

    // R2 R3: ready timing around one block
    h_key = CASES[5].h;
    do_start();
    check(ready, "R2 ready after start", 128'(ready), 128'd1);
    send(gen(32'h99, 0), 1'b0, 15, 1'b0);
    for (int i = 0; i < 8; i++) check(!ready, "R3 busy", 128'(ready), 128'd0);
    for (int i = 0; i < 8; i++) if (i < 7) tick();
    tick();
    check(ready, "R3 ready again", 128'(ready), 128'd1);

    // R10 R2: restart in the middle of a multiplication
    send(gen(32'h98, 0), 1'b1, 15, 1'b0);
    repeat (3) tick();
    run_case(CASES[1], "R10 restart mid-multiply", 1'b0);

    // R7: blocks offered during the length phase are ignored
    run_case(CASES[2], "R7 length phase ignore", 1'b1);
    run_case(CASES[5], "R7 length phase ignore b", 1'b1);

    report();
  end
endmodule